// File: doc/BRIEF.md
# Two-Wire Word Register Target

This block is the target side of an I2C link in front of a bank of 16-bit registers. It oversamples SCL and SDA with the system clock through synchronizers, finds START, repeated START and STOP, and decodes the address byte. It then runs one state machine through the byte phases of a write or a read. Every register access is one word carried as two bytes, most significant byte first. An internal word pointer selects the register. The pointer is loaded by the first byte after a write-direction address. It steps by one after each full byte pair.

The register bank sits outside the block and is reached through a plain port: `reg_addr` always shows the pointer, `reg_rdata` is read combinationally, and a one-cycle `reg_we` strobe carries `reg_wdata`. A high-speed master code is refused with NACK and raises `hs_mode` until the next STOP. `sda_oe` high means the block pulls SDA low; the pad wiring lives outside.

State machine (`ws_state_e`):
- `ST_IDLE`: bus free.
- `ST_RX_ADDR`: shifting in the address byte.
- `ST_ACK_ADDR`: acknowledging it.
- `ST_RX_PTR` / `ST_ACK_PTR`: pointer byte.
- `ST_RX_DHI` / `ST_ACK_DHI`: high write byte.
- `ST_RX_DLO` / `ST_ACK_DLO`: low write byte.
- `ST_TX_DHI` / `ST_MACK_HI`: high read byte and the master's answer.
- `ST_TX_DLO` / `ST_MACK_LO`: low read byte and the master's answer.
- `ST_IGNORE`: SDA released until the next START or STOP.

Transitions:
- Any state goes to `ST_IDLE` on STOP and to `ST_RX_ADDR` on START.
- `ST_RX_ADDR` goes to `ST_ACK_ADDR` on a matching address and to `ST_IGNORE` otherwise.
- `ST_ACK_ADDR` goes to `ST_RX_PTR` for a write and to `ST_TX_DHI` for a read.
- Each receive state moves to its acknowledge state after eight bits. `ST_ACK_PTR` then goes to `ST_RX_DHI`, `ST_ACK_DHI` to `ST_RX_DLO`, and `ST_ACK_DLO` back to `ST_RX_DHI`.
- Each transmit state moves to its master-answer state after eight bits. An ACK there goes on to the next transmit state: `ST_MACK_HI` to `ST_TX_DLO`, `ST_MACK_LO` to `ST_TX_DHI`. A NACK goes to `ST_IGNORE`.

Top module: `i2c_word_slave`

## Requirements
- R1: After reset, `sda_oe`, `hs_mode` and `reg_we` are 0 and the pointer is 00h, so a read with no pointer byte returns register 00h.
- R2: An address byte with bit 7 = 1 and bits 6:1 equal to `dev_addr` is acknowledged; bit 0 = 0 selects write, 1 selects read.
- R3: An address byte that does not match, including one with bit 7 = 0, is not acknowledged, and SDA stays released until the next START or STOP.
- R4: A write is address, pointer byte, high byte, low byte, each acknowledged. The word is committed as one `reg_we` pulse with `reg_addr` equal to the pointer and `reg_wdata` = {high, low}, only after the low byte's acknowledge.
- R5: The pointer steps by one after each complete byte pair, written or read, and does not move when a read stops after the high byte.
- R6: A random read (pointer write, repeated START, read-direction address) returns the selected register, high byte first, each byte MSB first.
- R7: The low byte is sent only if the master acknowledged the high byte; otherwise SDA stays released.
- R8: While the master acknowledges each low byte, reading continues with the next register; a NACK ends the read.
- R9: An address byte of the form 00001xxx is not acknowledged and sets `hs_mode`, which stays 1 across repeated STARTs and clears at STOP.
- R10: A START or STOP in the middle of a byte aborts the transfer; a partly received word is never written.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 6 | Device address compared with address-byte bits 6:1 |
| scl_in | input | 1 | SCL level from the pad |
| sda_in | input | 1 | SDA level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| hs_mode | output | 1 | High-speed mode flag |
| reg_addr | output | 8 | Word pointer to the register bank |
| reg_wdata | output | 16 | Word to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Word read at `reg_addr` |

## Verification
The assertions rely on a well-behaved master. It moves SDA only while SCL is low, except for START and STOP. It never makes START or STOP while the target is pulling SDA low. Each SCL phase lasts longer than the synchronizer and edge-detect delay. The bench master works in quarter-bit steps of eight clocks and changes levels on the falling clock edge. It releases SDA whenever the target owns the bit. The abort cases are placed only on bits the master itself drives.

// File: rtl/i2c_ws_pkg.sv
package i2c_ws_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX_ADDR,
        ST_ACK_ADDR,
        ST_RX_PTR,
        ST_ACK_PTR,
        ST_RX_DHI,
        ST_ACK_DHI,
        ST_RX_DLO,
        ST_ACK_DLO,
        ST_TX_DHI,
        ST_MACK_HI,
        ST_TX_DLO,
        ST_MACK_LO,
        ST_IGNORE
    } ws_state_e;

    // upper five bits of a high-speed master code
    localparam logic [4:0] HS_CODE_TOP = 5'b00001;

endpackage

// File: rtl/i2c_ws_sync.sv
module i2c_ws_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RESET_VAL}};
        else        pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2c_ws_events.sv
module i2c_ws_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_word_slave.sv
module i2c_word_slave
    import i2c_ws_pkg::*;
#(
    parameter int PTR_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [5:0]           dev_addr,
    input  logic                 scl_in,
    input  logic                 sda_in,
    output logic                 sda_oe,
    output logic                 hs_mode,
    output logic [PTR_W-1:0]     reg_addr,
    output logic [15:0]          reg_wdata,
    output logic                 reg_we,
    input  logic [15:0]          reg_rdata
);
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    // ---------------- input conditioning ----------------
    logic [1:0] raw_lines, sync_lines;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_evt, stop_evt;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        i2c_ws_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (sync_lines[g])
        );
    end

    assign scl_s = sync_lines[0];
    assign sda_s = sync_lines[1];

    i2c_ws_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    // ---------------- state and datapath ----------------
    ws_state_e          state, nxt;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  rx_sh, tx_sh, rd_lo, dhi;
    logic [PTR_W-1:0]   ptr;
    logic [WORD_W-1:0]  wdata_q;
    logic               we_q, hs_q, rw_q, mack_ok;
    logic               byte_in, last_out, addr_hit, mcode;

    assign byte_in  = scl_fall && (bit_cnt == CNT_FULL);
    assign last_out = scl_fall && (bit_cnt == CNT_LAST);
    assign addr_hit = rx_sh[7] && (rx_sh[6:1] == dev_addr);
    assign mcode    = (rx_sh[7:3] == HS_CODE_TOP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_evt) begin
            nxt = ST_IDLE;
        end else if (start_evt) begin
            nxt = ST_RX_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_RX_ADDR:  if (byte_in)  nxt = addr_hit ? ST_ACK_ADDR : ST_IGNORE;
                ST_ACK_ADDR: if (scl_fall) nxt = rw_q ? ST_TX_DHI : ST_RX_PTR;
                ST_RX_PTR:   if (byte_in)  nxt = ST_ACK_PTR;
                ST_ACK_PTR:  if (scl_fall) nxt = ST_RX_DHI;
                ST_RX_DHI:   if (byte_in)  nxt = ST_ACK_DHI;
                ST_ACK_DHI:  if (scl_fall) nxt = ST_RX_DLO;
                ST_RX_DLO:   if (byte_in)  nxt = ST_ACK_DLO;
                ST_ACK_DLO:  if (scl_fall) nxt = ST_RX_DHI;
                ST_TX_DHI:   if (last_out) nxt = ST_MACK_HI;
                ST_MACK_HI:  if (scl_fall) nxt = mack_ok ? ST_TX_DLO : ST_IGNORE;
                ST_TX_DLO:   if (last_out) nxt = ST_MACK_LO;
                ST_MACK_LO:  if (scl_fall) nxt = mack_ok ? ST_TX_DHI : ST_IGNORE;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            rd_lo   <= '0;
            dhi     <= '0;
            ptr     <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            hs_q    <= 1'b0;
            rw_q    <= 1'b0;
            mack_ok <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (we_q) ptr <= ptr + 1'b1;
            if (stop_evt) hs_q <= 1'b0;
            if (stop_evt || start_evt) begin
                bit_cnt <= '0;
            end else begin
                case (state)
                    ST_RX_ADDR, ST_RX_PTR, ST_RX_DHI, ST_RX_DLO: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (byte_in && state == ST_RX_ADDR) begin
                            rw_q <= rx_sh[0];
                            if (mcode) hs_q <= 1'b1;
                        end
                    end
                    ST_ACK_ADDR: if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw_q) begin
                            tx_sh <= reg_rdata[WORD_W-1:BYTE_W];
                            rd_lo <= reg_rdata[BYTE_W-1:0];
                        end
                    end
                    ST_ACK_PTR: if (scl_fall) begin
                        bit_cnt <= '0;
                        ptr     <= PTR_W'(rx_sh);
                    end
                    ST_ACK_DHI: if (scl_fall) begin
                        bit_cnt <= '0;
                        dhi     <= rx_sh;
                    end
                    ST_ACK_DLO: if (scl_fall) begin
                        bit_cnt <= '0;
                        wdata_q <= {dhi, rx_sh};
                        we_q    <= 1'b1;
                    end
                    ST_TX_DHI, ST_TX_DLO: if (scl_fall) begin
                        if (bit_cnt == CNT_LAST) begin
                            bit_cnt <= '0;
                            if (state == ST_TX_DLO) ptr <= ptr + 1'b1;
                        end else begin
                            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_MACK_HI: begin
                        if (scl_rise) mack_ok <= ~sda_s;
                        if (scl_fall && mack_ok) tx_sh <= rd_lo;
                    end
                    ST_MACK_LO: begin
                        if (scl_rise) mack_ok <= ~sda_s;
                        if (scl_fall && mack_ok) begin
                            tx_sh <= reg_rdata[WORD_W-1:BYTE_W];
                            rd_lo <= reg_rdata[BYTE_W-1:0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ACK_ADDR, ST_ACK_PTR, ST_ACK_DHI, ST_ACK_DLO: sda_oe = 1'b1;
            ST_TX_DHI, ST_TX_DLO:                            sda_oe = ~tx_sh[BYTE_W-1];
            default:                                         sda_oe = 1'b0;
        endcase
        hs_mode   = hs_q;
        reg_addr  = ptr;
        reg_wdata = wdata_q;
        reg_we    = we_q;
    end
endmodule

// File: rtl/i2c_ws_chk.sv
module i2c_ws_chk
    import i2c_ws_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_oe,
    input logic             hs_mode,
    input logic             reg_we,
    input logic [PTR_W-1:0] reg_addr,
    input logic             start_evt,
    input logic             stop_evt,
    input ws_state_e        state
);
    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));                       // R11

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);                                                // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == PTR_W'($past(reg_addr) + 1'b1)));           // R5

    AST_HS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !hs_mode);                                             // R9

    AST_NO_WRITE_ON_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt || stop_evt) |=> !reg_we);                               // R10

    AST_IGNORE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IGNORE && !$past(start_evt) && !$past(stop_evt))
            |-> (state == ST_IGNORE));                                      // R3
endmodule

bind i2c_word_slave i2c_ws_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .hs_mode  (hs_mode),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .state    (state)
);

// File: tb/tb_i2c_word_slave.sv
module tb_i2c_word_slave;
    localparam int         Q   = 8;
    localparam logic [5:0] DEV = 6'h25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        scl_in, sda_in, sda_oe, hs_mode, reg_we;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic [15:0] mem [256];
    logic [15:0] exp_mem [256];
    logic [23:0] exp_wr [$];
    int          checks = 0, failures = 0;
    logic        done = 1'b0;
    logic        prev_oe = 1'b0;

    always #2 clk = ~clk;

    assign scl_in    = scl_m;
    assign sda_in    = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    i2c_word_slave dut (
        .clk(clk), .rst_n(rst_n), .dev_addr(DEV),
        .scl_in(scl_in), .sda_in(sda_in), .sda_oe(sda_oe), .hs_mode(hs_mode),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [15:0] init_val(int i);
        return {8'(i) ^ 8'hC3, 8'(i)};
    endfunction

    // register bank model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // per-clock reference comparison: write strobes and SDA timing
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                if (exp_wr.size() == 0) begin
                    check(1'b0, "R10 unexpected write", {reg_addr, reg_wdata}, 32'h0);
                end else begin
                    logic [23:0] e;
                    e = exp_wr.pop_front();
                    check({reg_addr, reg_wdata} == e, "R4 write commit", {reg_addr, reg_wdata}, e);
                end
            end
            if (sda_oe != prev_oe)
                check(scl_m == 1'b0, "R11 sda change while scl low", scl_m, 1'b0);
            prev_oe <= sda_oe;
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic bit_cycle(input logic b, output logic r);
        sda_m = b; wq(); scl_m = 1'b1; wq(); r = sda_in; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_cycle(v[i], r);
        bit_cycle(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, r);
            v[i] = r;
        end
        bit_cycle(~give_ack, r);
    endtask

    task automatic wr_word(input logic [7:0] p, input logic [15:0] d);
        logic a;
        exp_wr.push_back({p, d});
        exp_mem[p] = d;
        i2c_start();
        send_byte({1'b1, DEV, 1'b0}, a); check(a, "R2 address ack (write)", a, 1);
        send_byte(p, a);                 check(a, "R4 pointer ack", a, 1);
        send_byte(d[15:8], a);           check(a, "R4 high byte ack", a, 1);
        send_byte(d[7:0], a);            check(a, "R4 low byte ack", a, 1);
        i2c_stop();
    endtask

    task automatic rd_word(input logic [7:0] p, output logic [15:0] d);
        logic a;
        logic [7:0] h, l;
        i2c_start();
        send_byte({1'b1, DEV, 1'b0}, a); check(a, "R6 dummy write ack", a, 1);
        send_byte(p, a);                 check(a, "R6 pointer ack", a, 1);
        i2c_start();
        send_byte({1'b1, DEV, 1'b1}, a); check(a, "R6 read address ack", a, 1);
        recv_byte(1'b1, h);
        recv_byte(1'b0, l);
        i2c_stop();
        d = {h, l};
    endtask

    initial begin
        logic a;
        logic [7:0] h, l;
        logic [15:0] d;
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        repeat (10) @(negedge clk);
        check(sda_oe == 1'b0 && hs_mode == 1'b0 && reg_we == 1'b0, "R1 reset outputs",
              {sda_oe, hs_mode, reg_we}, 0);
        rst_n = 1'b1;
        wq();

        // R1: current-address read right after reset
        i2c_start();
        send_byte({1'b1, DEV, 1'b1}, a); check(a, "R2 address ack (read)", a, 1);
        recv_byte(1'b1, h); recv_byte(1'b0, l);
        i2c_stop();
        check({h, l} == exp_mem[0], "R1 read starts at 00h", {h, l}, exp_mem[0]);

        // R4/R6: write then random read back
        wr_word(8'h05, 16'hA1B2);
        rd_word(8'h05, d);
        check(d == 16'hA1B2, "R6 random read MSB first", d, 16'hA1B2);

        // R8/R5: sequential read across two registers
        i2c_start();
        send_byte({1'b1, DEV, 1'b0}, a);
        send_byte(8'h10, a);
        i2c_start();
        send_byte({1'b1, DEV, 1'b1}, a);
        recv_byte(1'b1, h); recv_byte(1'b1, l);
        check({h, l} == exp_mem[8'h10], "R8 first word", {h, l}, exp_mem[8'h10]);
        recv_byte(1'b1, h); recv_byte(1'b0, l);
        i2c_stop();
        check({h, l} == exp_mem[8'h11], "R5 pointer step on read", {h, l}, exp_mem[8'h11]);

        // R7: master refuses high byte, low byte must not be driven
        i2c_start();
        send_byte({1'b1, DEV, 1'b0}, a);
        send_byte(8'h20, a);
        i2c_start();
        send_byte({1'b1, DEV, 1'b1}, a);
        recv_byte(1'b0, h);
        check(h == exp_mem[8'h20][15:8], "R7 high byte", h, exp_mem[8'h20][15:8]);
        recv_byte(1'b0, l);
        i2c_stop();
        check(l == 8'hFF, "R7 low byte withheld", l, 8'hFF);
        // R5: pointer did not move after the incomplete pair
        i2c_start();
        send_byte({1'b1, DEV, 1'b1}, a);
        recv_byte(1'b1, h); recv_byte(1'b0, l);
        i2c_stop();
        check({h, l} == exp_mem[8'h20], "R5 no step on half pair", {h, l}, exp_mem[8'h20]);

        // R5: two words in one write transaction
        exp_wr.push_back({8'h30, 16'h1234}); exp_mem[8'h30] = 16'h1234;
        exp_wr.push_back({8'h31, 16'h5678}); exp_mem[8'h31] = 16'h5678;
        i2c_start();
        send_byte({1'b1, DEV, 1'b0}, a);
        send_byte(8'h30, a);
        send_byte(8'h12, a); send_byte(8'h34, a);
        send_byte(8'h56, a); send_byte(8'h78, a);
        check(a, "R5 second pair ack", a, 1);
        i2c_stop();
        rd_word(8'h31, d);
        check(d == 16'h5678, "R5 write pointer step", d, 16'h5678);

        // R3: wrong device address, then a byte that must stay unanswered
        i2c_start();
        send_byte({1'b1, DEV ^ 6'h01, 1'b0}, a);
        check(!a, "R3 wrong address nack", a, 0);
        send_byte(8'h00, a);
        check(!a, "R3 stays released", a, 0);
        i2c_stop();
        // R3: top bit clear
        i2c_start();
        send_byte({1'b0, DEV, 1'b0}, a);
        check(!a, "R3 top bit zero nack", a, 0);
        i2c_stop();

        // R9: master code then a write in high-speed mode
        i2c_start();
        send_byte(8'h0B, a);
        check(!a, "R9 master code nack", a, 0);
        check(hs_mode == 1'b1, "R9 hs_mode set", hs_mode, 1);
        exp_wr.push_back({8'h40, 16'hCAFE}); exp_mem[8'h40] = 16'hCAFE;
        i2c_start();
        send_byte({1'b1, DEV, 1'b0}, a);
        send_byte(8'h40, a); send_byte(8'hCA, a); send_byte(8'hFE, a);
        check(a, "R9 write ack in hs mode", a, 1);
        check(hs_mode == 1'b1, "R9 hs_mode kept across repeated start", hs_mode, 1);
        i2c_stop();
        wq();
        check(hs_mode == 1'b0, "R9 hs_mode cleared at stop", hs_mode, 0);

        // R10: STOP inside the low byte
        i2c_start();
        send_byte({1'b1, DEV, 1'b0}, a);
        send_byte(8'h05, a); send_byte(8'h77, a);
        for (int i = 0; i < 4; i++) bit_cycle(1'b0, a);
        i2c_stop();
        // R10: START inside the high byte
        i2c_start();
        send_byte({1'b1, DEV, 1'b0}, a);
        send_byte(8'h05, a);
        for (int i = 0; i < 3; i++) bit_cycle(1'b1, a);
        i2c_start();
        send_byte({1'b1, DEV, 1'b1}, a);
        recv_byte(1'b1, h); recv_byte(1'b0, l);
        i2c_stop();
        check({h, l} == 16'hA1B2, "R10 aborted word not written", {h, l}, 16'hA1B2);
        check(exp_wr.size() == 0, "R4 all expected writes seen", exp_wr.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end
endmodule